// File: doc/BRIEF.md
# Interrupt Context Exchange Engine

When an interrupt is taken, this engine trades the processor's running context for a context block stored in memory. The running context is eight scalar registers, eight address registers, the program counter and the monitor flags. It is packed into sixteen memory words at a base address that comes from an exchange-address register. The engine walks the sixteen words in ascending order. For each word it reads the stored value, keeps it in an incoming buffer, and then writes the outgoing value to the same address. When the last word has been written, the whole incoming context is loaded into the processor in a single cycle.

The processor presents its context on a parallel snapshot port. The engine latches that snapshot on the cycle it accepts the interrupt, so the processor is free to change it afterwards. The memory is a single-port synchronous RAM with one cycle of read latency. Each word therefore costs one read cycle followed by one write cycle. A full exchange takes 32 memory cycles plus one load cycle. Priority between interrupts and nesting of interrupts are left to the surrounding logic.

Top module: `ctx_exchange`

## Requirements
- R1: While reset is held and in the first cycle after it, `busy`, `done`, `ld_en`, `mem_en` and `mem_we` are all low.
- R2: When `irq` is high on a clock edge and the engine is idle, `busy` goes high in the next cycle. That same cycle is a read (`mem_en`=1, `mem_we`=0) of address `xchg_base`, using the value `xchg_base` had at the accepting edge.
- R3: Each word k, for k = 0 to 15 in ascending order, uses exactly two cycles. The first is a read cycle (`mem_en`=1, `mem_we`=0) and the second is a write cycle (`mem_en`=1, `mem_we`=1). Both go to address (base + k) mod 2^ADDR_W.
- R4: The outgoing words follow a fixed layout. For k = 0 to 7, bits [AREG_W-1:0] of word k hold address register k. Bits [DATA_W-1 -: PC_W] of word 0 hold the program counter. Bits [DATA_W-1 -: FLAG_W] of word 1 hold the flags. All other bits of words 0 to 7 are zero. Word 8+k holds scalar register k.
- R5: The outgoing words come from the snapshot latched at the accepting edge. Changes to the snapshot inputs after that edge do not affect them.
- R6: The value on `mem_rdata` in each write cycle is taken as incoming word k. In the load cycle, the load outputs carry the incoming words decoded with the R4 layout. Bits that are unused in that layout are discarded.
- R7: The load cycle is the 33rd cycle after the accepting edge. In it, `done` and `ld_en` are both high for exactly that one cycle. In the next cycle, `busy` is low.
- R8: An `irq` that arrives while `busy` is high, including the load cycle, starts nothing. If `irq` is still high in the idle cycle after the load cycle, a new exchange begins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq | input | 1 | Interrupt request, sampled while idle |
| xchg_base | input | ADDR_W | Value of the exchange-address register |
| sreg_snap | input | 8*DATA_W | Scalar registers of the running context, register k at bits [k*DATA_W +: DATA_W] |
| areg_snap | input | 8*AREG_W | Address registers of the running context |
| pc_snap | input | PC_W | Program counter of the running context |
| flags_snap | input | FLAG_W | Monitor flags of the running context |
| ld_en | output | 1 | Load strobe for the incoming context |
| sreg_load | output | 8*DATA_W | Incoming scalar registers |
| areg_load | output | 8*AREG_W | Incoming address registers |
| pc_load | output | PC_W | Incoming program counter |
| flags_load | output | FLAG_W | Incoming monitor flags |
| mem_en | output | 1 | Memory access enable |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | ADDR_W | Memory word address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_rdata | input | DATA_W | Memory read data, one cycle after the read |
| busy | output | 1 | Exchange in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
A wrong step counter shows up at the memory port within one cycle. It appears as a missing read/write alternation, a wrong address, or a `done` that comes early or late.

A fault in latching or packing the snapshot shows up on `mem_wdata` in the write cycle of the word concerned. A fault in capturing or unpacking the incoming words stays hidden until the load cycle, where the load outputs disagree with the memory contents from before the exchange. Running a second exchange at the same base makes the earlier write data come back as incoming data, so a write-path error also appears at the load outputs.

// File: rtl/ctx_exchange.sv
module ctx_exchange #(
  parameter int DATA_W = 64,
  parameter int AREG_W = 24,
  parameter int PC_W   = 22,
  parameter int FLAG_W = 8,
  parameter int ADDR_W = 12
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  irq,
  input  logic [ADDR_W-1:0]     xchg_base,
  input  logic [8*DATA_W-1:0]   sreg_snap,
  input  logic [8*AREG_W-1:0]   areg_snap,
  input  logic [PC_W-1:0]       pc_snap,
  input  logic [FLAG_W-1:0]     flags_snap,
  output logic                  ld_en,
  output logic [8*DATA_W-1:0]   sreg_load,
  output logic [8*AREG_W-1:0]   areg_load,
  output logic [PC_W-1:0]       pc_load,
  output logic [FLAG_W-1:0]     flags_load,
  output logic                  mem_en,
  output logic                  mem_we,
  output logic [ADDR_W-1:0]     mem_addr,
  output logic [DATA_W-1:0]     mem_wdata,
  input  logic [DATA_W-1:0]     mem_rdata,
  output logic                  busy,
  output logic                  done
);
  localparam int NREG   = 8;
  localparam int NWORD  = 2 * NREG;
  localparam int IDX_W  = $clog2(NWORD);
  localparam int LAST   = 2 * NWORD + 1;
  localparam int STEP_W = $clog2(LAST + 1);

  // step 0: idle; odd 1..2N-1: read; even 2..2N: write; LAST: load
  logic [STEP_W-1:0] step, step_m1;
  logic [IDX_W-1:0]  idx;
  logic [ADDR_W-1:0] base;
  logic [DATA_W-1:0] out_buf [NWORD];
  logic [DATA_W-1:0] in_buf  [NWORD];
  logic [DATA_W-1:0] packed_w [NWORD];

  assign step_m1 = step - STEP_W'(1);
  assign idx     = step_m1[IDX_W:1];
  assign busy    = (step != '0);
  assign done    = (step == STEP_W'(LAST));
  assign ld_en   = done;
  assign mem_en  = busy && !done;
  assign mem_we  = mem_en && !step[0];
  assign mem_addr  = base + {{(ADDR_W-IDX_W){1'b0}}, idx};
  assign mem_wdata = out_buf[idx];

  always_comb begin
    for (int i = 0; i < NREG; i++) begin
      packed_w[i] = '0;
      packed_w[i][AREG_W-1:0] = areg_snap[i*AREG_W +: AREG_W];
      packed_w[NREG+i] = sreg_snap[i*DATA_W +: DATA_W];
    end
    packed_w[0][DATA_W-1 -: PC_W]   = pc_snap;
    packed_w[1][DATA_W-1 -: FLAG_W] = flags_snap;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step <= '0;
      base <= '0;
      for (int i = 0; i < NWORD; i++) begin
        out_buf[i] <= '0;
        in_buf[i]  <= '0;
      end
    end else if (!busy) begin
      if (irq) begin
        step <= STEP_W'(1);
        base <= xchg_base;
        for (int i = 0; i < NWORD; i++) out_buf[i] <= packed_w[i];
      end
    end else begin
      step <= done ? '0 : step + STEP_W'(1);
      if (mem_we) in_buf[idx] <= mem_rdata;
    end
  end

  for (genvar g = 0; g < NREG; g++) begin : g_unpack
    assign areg_load[g*AREG_W +: AREG_W] = in_buf[g][AREG_W-1:0];
    assign sreg_load[g*DATA_W +: DATA_W] = in_buf[NREG+g];
  end
  assign pc_load    = in_buf[0][DATA_W-1 -: PC_W];
  assign flags_load = in_buf[1][DATA_W-1 -: FLAG_W];

  assert_we_needs_en_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> mem_en);
  assert_write_after_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> ($past(mem_en && !mem_we) && mem_addr == $past(mem_addr)));
  assert_addr_ascends_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en && !mem_we && $past(mem_we)) |-> mem_addr == $past(mem_addr) + ADDR_W'(1));
  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done && !busy);
  assert_load_after_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(mem_we));
  assert_busy_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> busy);
endmodule

// File: tb/ctx_exchange_test.sv
module ctx_exchange_test;
  localparam int DW = 64, AW = 24, PW = 22, FW = 8, MW = 12;
  localparam int MSZ = 1 << MW;

  logic clk = 0, rst_n = 0, irq = 0;
  logic [MW-1:0]   xbase = '0;
  logic [8*DW-1:0] s_in = '0;
  logic [8*AW-1:0] a_in = '0;
  logic [PW-1:0]   pc_in = '0;
  logic [FW-1:0]   fl_in = '0;
  logic ld_en, mem_en, mem_we, busy, done;
  logic [8*DW-1:0] s_ld;
  logic [8*AW-1:0] a_ld;
  logic [PW-1:0]   pc_ld;
  logic [FW-1:0]   fl_ld;
  logic [MW-1:0]   mem_addr;
  logic [DW-1:0]   mem_wdata, mem_rdata;

  always #4 clk = ~clk;

  ctx_exchange uut (
    .clk(clk), .rst_n(rst_n), .irq(irq), .xchg_base(xbase),
    .sreg_snap(s_in), .areg_snap(a_in), .pc_snap(pc_in), .flags_snap(fl_in),
    .ld_en(ld_en), .sreg_load(s_ld), .areg_load(a_ld), .pc_load(pc_ld), .flags_load(fl_ld),
    .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .busy(busy), .done(done));

  logic [DW-1:0] bmem [MSZ];
  initial begin
    for (int i = 0; i < MSZ; i++)
      bmem[i] = {32'(i) * 32'h9E3779B1, ~(32'(i) * 32'h85EBCA77)};
  end
  always @(posedge clk) begin
    if (mem_en && mem_we) bmem[mem_addr] <= mem_wdata;
    else if (mem_en) mem_rdata <= bmem[mem_addr];
  end

  int checks = 0, errors = 0, cyc = 0;
  bit fin = 0;

  task automatic chk(input bit ok, input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  function automatic logic [DW-1:0] ref_word(int w);
    logic [DW-1:0] v;
    if (w >= 8) return s_in[(w-8)*DW +: DW];
    v = DW'(a_in[w*AW +: AW]);
    if (w == 0) v = v | (DW'(pc_in) << (DW - PW));
    if (w == 1) v = v | (DW'(fl_in) << (DW - FW));
    return v;
  endfunction

  int ph = 0;
  logic [MW-1:0] m_base;
  logic [DW-1:0] m_out [16];
  logic [DW-1:0] m_in  [16];

  always @(negedge clk) begin
    if (!rst_n) begin
      ph = 0;
      chk({busy, done, ld_en, mem_en, mem_we} == 5'b0, "R1 reset", DW'({busy, done, ld_en, mem_en, mem_we}), 0);
    end else begin
      int w;
      logic [4:0] exp_c;
      w = (ph - 1) / 2;
      if (ph == 0) exp_c = 5'b00000;
      else if (ph == 33) exp_c = 5'b11100;
      else exp_c = {1'b1, 1'b0, 1'b0, 1'b1, (ph % 2 == 0)};
      chk({busy, done, ld_en, mem_en, mem_we} == exp_c,
          ph == 1 ? "R2 start" : (ph == 33 ? "R7 done" : (irq && ph != 0 ? "R8 irq ignored" : "R3 sequence")),
          DW'({busy, done, ld_en, mem_en, mem_we}), DW'(exp_c));
      if (ph >= 1 && ph <= 32) begin
        chk(mem_addr == m_base + MW'(w), ph == 1 ? "R2 base" : "R3 addr", DW'(mem_addr), DW'(m_base + MW'(w)));
        if (ph % 2 == 0) chk(mem_wdata == m_out[w], "R4/R5 wdata", mem_wdata, m_out[w]);
      end
      if (ph == 33) begin
        for (int i = 0; i < 8; i++) begin
          chk(a_ld[i*AW +: AW] == m_in[i][AW-1:0], "R6 areg", DW'(a_ld[i*AW +: AW]), DW'(m_in[i][AW-1:0]));
          chk(s_ld[i*DW +: DW] == m_in[8+i], "R6 sreg", s_ld[i*DW +: DW], m_in[8+i]);
        end
        chk(pc_ld == m_in[0][DW-1 -: PW], "R6 pc", DW'(pc_ld), DW'(m_in[0][DW-1 -: PW]));
        chk(fl_ld == m_in[1][DW-1 -: FW], "R6 flags", DW'(fl_ld), DW'(m_in[1][DW-1 -: FW]));
      end
      if (ph == 0) begin
        if (irq) begin
          ph = 1;
          m_base = xbase;
          for (int k = 0; k < 16; k++) begin
            m_out[k] = ref_word(k);
            m_in[k]  = bmem[MW'(xbase + MW'(k))];
          end
        end
      end else ph = (ph == 33) ? 0 : ph + 1;
    end
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic set_ctx(input int seed);
    for (int i = 0; i < 8; i++) begin
      s_in[i*DW +: DW] = {32'(seed * 7 + i) * 32'h01000193, 32'(seed + i * 13) ^ 32'hA5A5_0F0F};
      a_in[i*AW +: AW] = AW'(seed * 1000 + i * 37 + 5);
    end
    pc_in = PW'(seed * 32'h1357 + 3);
    fl_in = FW'(seed * 29 + 1);
  endtask

  task automatic pulse(input logic [MW-1:0] b);
    xbase = b;
    irq = 1;
    tick(1);
    irq = 0;
  endtask

  initial begin
    tick(3);
    rst_n = 1;
    tick(2);
    set_ctx(1);
    pulse(12'h100);
    tick(5);
    set_ctx(2);           // R5: snapshot change mid-exchange
    xbase = 12'h300;
    tick(3);
    irq = 1; tick(1); irq = 0;  // R8: request while busy
    tick(40);
    set_ctx(3);
    pulse(12'h100);       // incoming equals the context written earlier
    tick(40);
    set_ctx(4);
    pulse(12'hFF8);       // R3: address wrap
    tick(40);
    set_ctx(5);
    xbase = 12'h200;
    irq = 1;              // R8: held through done, back-to-back exchange
    tick(70);
    irq = 0;
    tick(40);
    fin = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !fin) begin
      fin = 1;
      checks++;
      errors++;
      $display("FAIL R7 watchdog act=running exp=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule